// File: doc/BRIEF.md
# Bidirectional DShot Telemetry Decoder

After a bidirectional DShot command the motor controller answers on the same wire. An edge-capture unit timestamps every rising and falling edge of that answer with a free-running 16-bit counter. That counter ticks at an integer oversampling factor (`OSR`) times the telemetry bit rate. The telemetry bit rate is 5/4 of the command bit rate, for the 150, 300, 600 and 1200 kbit/s modes.

This block takes those timestamps one per cycle and converts each gap between edges into a run length. From the runs it rebuilds the 21-bit line word: each run is a one followed by zeros, and a final inferred run fills out the frame. It then maps the four 5-bit groups back to nibbles and checks the nibble checksum. The result is a 12-bit payload with a one-cycle completion pulse and a single status flag.

The capture unit streams the timestamps on `edge_vld_i`/`edge_time_i`. It then raises `frame_end_i` for one cycle, with the number of edges it captured on `edge_cnt_i`. The decoder clears itself on that strobe and is ready for the next frame in the following cycle.

Top module: `dshot_telem_dec`

## Requirements
- R1: While `rst_ni` is low and until the first frame ends, `done_o` and all status flags are 0 and `payload_o` is 0xFFF.
- R2: A gap between consecutive accepted timestamps is taken modulo 2^16 (a counter wrap inside a frame decodes normally). Its run length is floor((gap + OSR/2) / OSR).
- R3: Each run of length L shifts the word left by L and sets bit L-1 of the new low part. The first timestamp only opens the frame. Once exactly 21 bits have accumulated, later timestamps are ignored. At `frame_end_i`, if fewer than 21 bits exist, one run of (21 − bits) is appended. Bit 20 of the finished word is the leading one; bits 19:0 carry the code groups.
- R4: A run length of 0, or one that would carry the total past 21 bits, makes the frame a length error. `len_err_o` is set and `payload_o` is 0xFFF.
- R5: Bits [4:0], [9:5], [14:10] and [19:15] of the word decode to the nibbles at bits [3:0], [7:4], [11:8] and [15:12] of a 16-bit value. The code-to-nibble map is: 0x19→0, 0x1B→1, 0x12→2, 0x13→3, 0x1D→4, 0x15→5, 0x16→6, 0x17→7, 0x1A→8, 0x09→9, 0x0A→A, 0x0B→B, 0x1E→C, 0x0D→D, 0x0E→E, 0x0F→F. Any other code sets `code_err_o` and gives payload 0xFFF.
- R6: The XOR of the four nibbles of the 16-bit value must be 0xF. Otherwise `csum_err_o` is set and the payload is 0xFFF.
- R7: A frame with none of the errors sets `valid_o` and drives `payload_o` with bits [15:4] of the decoded value.
- R8: A frame whose `edge_cnt_i` is 0 at `frame_end_i` sets `no_resp_o`, whatever timestamps arrived, and gives payload 0xFFF.
- R9: `done_o` is high in exactly the cycle after `frame_end_i` is sampled. In that cycle exactly one of `valid_o`, `no_resp_o`, `len_err_o`, `code_err_o`, `csum_err_o` is set, in that priority order (no-response first, then length, code, checksum). In every other cycle all flags are 0 and `payload_o` holds its last value.
- R10: A timestamp presented in the same cycle as `frame_end_i` is dropped. Each frame starts from an empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| edge_vld_i | input | 1 | Timestamp strobe |
| edge_time_i | input | 16 | Captured counter value of an edge |
| frame_end_i | input | 1 | End of capture window |
| edge_cnt_i | input | 6 | Number of edges captured in the window |
| done_o | output | 1 | Result pulse |
| valid_o | output | 1 | Frame decoded and checksum correct |
| no_resp_o | output | 1 | No edges captured |
| len_err_o | output | 1 | Run lengths do not form a 21-bit frame |
| code_err_o | output | 1 | A 5-bit group is not a valid code |
| csum_err_o | output | 1 | Nibble checksum is not 0xF |
| payload_o | output | 12 | Decoded payload, 0xFFF on any failure |

## Verification
The hardest state to reach from the ports is a frame whose 21st bit is completed by a real gap rather than the inferred run. Later edges must then be ignored. The stimulus takes a legal frame and appends an explicit timestamp where the inferred run would end, followed by garbage edges, and expects the same payload. Jittered gaps of up to ±3 ticks with OSR 8 exercise the rounding. Random start times put counter wraps inside frames. Directed gaps of a few ticks and of 22 or more bit times reach both sides of the length-error boundary.

// File: rtl/dshot_telem_pkg.sv
package dshot_telem_pkg;
  localparam int FRAME_BITS = 21;
  localparam int CODE_BITS  = FRAME_BITS - 1;
  localparam int GROUPS     = 4;
  localparam int CNT_BITS   = 5;

  // returns {ok, nibble}
  function automatic logic [4:0] gcr_to_nib(input logic [4:0] code);
    unique case (code)
      5'h19: gcr_to_nib = 5'h10;
      5'h1B: gcr_to_nib = 5'h11;
      5'h12: gcr_to_nib = 5'h12;
      5'h13: gcr_to_nib = 5'h13;
      5'h1D: gcr_to_nib = 5'h14;
      5'h15: gcr_to_nib = 5'h15;
      5'h16: gcr_to_nib = 5'h16;
      5'h17: gcr_to_nib = 5'h17;
      5'h1A: gcr_to_nib = 5'h18;
      5'h09: gcr_to_nib = 5'h19;
      5'h0A: gcr_to_nib = 5'h1A;
      5'h0B: gcr_to_nib = 5'h1B;
      5'h1E: gcr_to_nib = 5'h1C;
      5'h0D: gcr_to_nib = 5'h1D;
      5'h0E: gcr_to_nib = 5'h1E;
      5'h0F: gcr_to_nib = 5'h1F;
      default: gcr_to_nib = 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/dshot_run_acc.sv
module dshot_run_acc
  import dshot_telem_pkg::*;
#(
  parameter int TS_W = 16,
  parameter int OSR  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 edge_vld_i,
  input  logic [TS_W-1:0]      edge_time_i,
  input  logic                 clear_i,
  output logic [CODE_BITS-1:0] word_o,
  output logic                 len_err_o
);
  localparam int HALF = OSR / 2;
  localparam int LW   = TS_W + 1;

  logic                 have_q, err_q;
  logic [TS_W-1:0]      prev_q;
  logic [CNT_BITS-1:0]  bits_q, room;
  logic [CODE_BITS-1:0] val_q;
  logic [TS_W-1:0]      gap;
  logic [LW-1:0]        run_len;
  logic [CNT_BITS-1:0]  run_sh;
  logic                 bad_run, take, full;

  assign gap     = edge_time_i - prev_q;  // modulo 2^TS_W
  assign run_len = ({1'b0, gap} + LW'(HALF)) / LW'(OSR);
  assign run_sh  = run_len[CNT_BITS-1:0];
  assign room    = CNT_BITS'(FRAME_BITS) - bits_q;
  assign full    = (bits_q == CNT_BITS'(FRAME_BITS));
  assign bad_run = (run_len == '0) || (run_len > LW'(room));
  assign take    = edge_vld_i && !clear_i && !err_q && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      err_q  <= 1'b0;
      prev_q <= '0;
      bits_q <= '0;
      val_q  <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      err_q  <= 1'b0;
      prev_q <= '0;
      bits_q <= '0;
      val_q  <= '0;
    end else if (take) begin
      have_q <= 1'b1;
      prev_q <= edge_time_i;
      if (have_q) begin
        if (bad_run) begin
          err_q <= 1'b1;
        end else begin
          val_q  <= (val_q << run_sh) | (CODE_BITS'(1) << (run_sh - CNT_BITS'(1)));
          bits_q <= bits_q + run_sh;
        end
      end
    end
  end

  // bit 20 (leading one) is implicit; the inferred last run fills the frame
  always_comb begin
    if (full) word_o = val_q;
    else      word_o = (val_q << room) | (CODE_BITS'(1) << (room - CNT_BITS'(1)));
  end
  assign len_err_o = err_q;
endmodule

// File: rtl/dshot_gcr_dec.sv
module dshot_gcr_dec
  import dshot_telem_pkg::*;
(
  input  logic [CODE_BITS-1:0] word_i,
  output logic [15:0]          data_o,
  output logic                 code_ok_o,
  output logic                 csum_ok_o
);
  logic [GROUPS-1:0] grp_ok;
  logic [15:0]       x1, x2;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [4:0] res;
    assign res            = gcr_to_nib(word_i[5*g +: 5]);
    assign grp_ok[g]      = res[4];
    assign data_o[4*g +: 4] = res[3:0];
  end

  assign code_ok_o = &grp_ok;
  assign x1        = data_o ^ (data_o >> 8);
  assign x2        = x1 ^ (x1 >> 4);
  assign csum_ok_o = (x2[3:0] == 4'hF);
endmodule

// File: rtl/dshot_telem_dec.sv
module dshot_telem_dec
  import dshot_telem_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int OSR   = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_vld_i,
  input  logic [TS_W-1:0]  edge_time_i,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] edge_cnt_i,
  output logic             done_o,
  output logic             valid_o,
  output logic             no_resp_o,
  output logic             len_err_o,
  output logic             code_err_o,
  output logic             csum_err_o,
  output logic [11:0]      payload_o
);
  logic [CODE_BITS-1:0] word;
  logic [15:0]          data;
  logic                 acc_err, code_ok, csum_ok;
  logic                 nr_n, le_n, ce_n, cs_n, ok_n;

  dshot_run_acc #(.TS_W(TS_W), .OSR(OSR)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_vld_i (edge_vld_i),
    .edge_time_i(edge_time_i),
    .clear_i    (frame_end_i),
    .word_o     (word),
    .len_err_o  (acc_err)
  );

  dshot_gcr_dec u_dec (
    .word_i   (word),
    .data_o   (data),
    .code_ok_o(code_ok),
    .csum_ok_o(csum_ok)
  );

  assign nr_n = (edge_cnt_i == '0);
  assign le_n = !nr_n && acc_err;
  assign ce_n = !nr_n && !acc_err && !code_ok;
  assign cs_n = !nr_n && !acc_err && code_ok && !csum_ok;
  assign ok_n = !nr_n && !acc_err && code_ok && csum_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      valid_o    <= 1'b0;
      no_resp_o  <= 1'b0;
      len_err_o  <= 1'b0;
      code_err_o <= 1'b0;
      csum_err_o <= 1'b0;
      payload_o  <= 12'hFFF;
    end else begin
      done_o     <= frame_end_i;
      valid_o    <= frame_end_i && ok_n;
      no_resp_o  <= frame_end_i && nr_n;
      len_err_o  <= frame_end_i && le_n;
      code_err_o <= frame_end_i && ce_n;
      csum_err_o <= frame_end_i && cs_n;
      if (frame_end_i) payload_o <= ok_n ? data[15:4] : 12'hFFF;
    end
  end
endmodule

// File: rtl/dshot_telem_chk.sv
module dshot_telem_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_end_i,
  input logic [CNT_W-1:0] edge_cnt_i,
  input logic             done_o,
  input logic             valid_o,
  input logic             no_resp_o,
  input logic             len_err_o,
  input logic             code_err_o,
  input logic             csum_err_o,
  input logic [11:0]      payload_o
);
  AST_DONE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(frame_end_i)); // R9
  AST_END_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> done_o); // R9
  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o}) == 1); // R9
  AST_QUIET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> {valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o} == 5'b0); // R9
  AST_HOLD_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_end_i) |-> $stable(payload_o)); // R9
  AST_FAIL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !valid_o) |-> payload_o == 12'hFFF); // R4
  AST_NO_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (no_resp_o == ($past(edge_cnt_i) == '0))); // R8
endmodule

bind dshot_telem_dec dshot_telem_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_end_i(frame_end_i),
  .edge_cnt_i (edge_cnt_i),
  .done_o     (done_o),
  .valid_o    (valid_o),
  .no_resp_o  (no_resp_o),
  .len_err_o  (len_err_o),
  .code_err_o (code_err_o),
  .csum_err_o (csum_err_o),
  .payload_o  (payload_o)
);

// File: tb/dshot_telem_dec_test.sv
module dshot_telem_dec_test;
  localparam int OSR = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        edge_vld_i = 1'b0;
  logic [15:0] edge_time_i = '0;
  logic        frame_end_i = 1'b0;
  logic [5:0]  edge_cnt_i = '0;
  logic        done_o, valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o;
  logic [11:0] payload_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] ts [64];

  always #10 clk_i = ~clk_i;

  dshot_telem_dec #(.OSR(OSR)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_vld_i(edge_vld_i), .edge_time_i(edge_time_i),
    .frame_end_i(frame_end_i), .edge_cnt_i(edge_cnt_i), .done_o(done_o), .valid_o(valid_o),
    .no_resp_o(no_resp_o), .len_err_o(len_err_o), .code_err_o(code_err_o),
    .csum_err_o(csum_err_o), .payload_o(payload_o)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'h19; 4'h1: enc = 5'h1B; 4'h2: enc = 5'h12; 4'h3: enc = 5'h13;
      4'h4: enc = 5'h1D; 4'h5: enc = 5'h15; 4'h6: enc = 5'h16; 4'h7: enc = 5'h17;
      4'h8: enc = 5'h1A; 4'h9: enc = 5'h09; 4'hA: enc = 5'h0A; 4'hB: enc = 5'h0B;
      4'hC: enc = 5'h1E; 4'hD: enc = 5'h0D; 4'hE: enc = 5'h0E; default: enc = 5'h0F;
    endcase
  endfunction

  // expected {done, valid, no_resp, len_err, code_err, csum_err, payload}
  function automatic logic [17:0] model(input int n, input int cnt);
    int bits = 0;
    longint val = 0;
    bit err = 0;
    bit cok = 1;
    logic [15:0] d = '0;
    logic [3:0] x;
    if (cnt == 0) return {6'b101000, 12'hFFF};
    for (int i = 1; i < n; i++) begin
      int gap, len;
      if (err || bits == 21) break;
      gap = int'(16'(ts[i] - ts[i-1]));
      len = (gap + OSR / 2) / OSR;
      if (len == 0 || bits + len > 21) err = 1;
      else begin val = (val << len) | (64'd1 << (len - 1)); bits += len; end
    end
    if (err) return {6'b100100, 12'hFFF};
    if (bits < 21) val = (val << (21 - bits)) | (64'd1 << (20 - bits));
    for (int g = 0; g < 4; g++) begin
      bit hit = 0;
      for (int k = 0; k < 16; k++)
        if (enc(4'(k)) == 5'(val >> (5 * g))) begin d[4*g +: 4] = 4'(k); hit = 1; end
      if (!hit) cok = 0;
    end
    if (!cok) return {6'b100010, 12'hFFF};
    x = d[3:0] ^ d[7:4] ^ d[11:8] ^ d[15:12];
    if (x != 4'hF) return {6'b100001, 12'hFFF};
    return {6'b110000, d[15:4]};
  endfunction

  // build timestamps for a 20-bit code word; returns edge count
  function automatic int build(input logic [19:0] code, input logic [15:0] t0, input bit jit);
    logic [20:0] line = {1'b1, code};
    int k = 0;
    int lastp = 20;
    for (int p = 20; p >= 0; p--) begin
      if (line[p]) begin
        if (k == 0) ts[0] = t0;
        else ts[k] = ts[k-1] + 16'((lastp - p) * OSR + (jit ? $urandom_range(0, 6) - 3 : 0));
        lastp = p;
        k++;
      end
    end
    return k;
  endfunction

  function automatic logic [19:0] code_of(input logic [11:0] pl, input bit good_cs);
    logic [3:0] cs = 4'hF ^ pl[3:0] ^ pl[7:4] ^ pl[11:8];
    if (!good_cs) cs = cs ^ 4'h1;
    return {enc(pl[11:8]), enc(pl[7:4]), enc(pl[3:0]), enc(cs)};
  endfunction

  function automatic string tag_of(input logic [17:0] e);
    if (e[15]) return "R8";
    if (e[14]) return "R4";
    if (e[13]) return "R5";
    if (e[12]) return "R6";
    return "R7";
  endfunction

  task automatic run_frame(input int n, input int cnt, input string tag);
    logic [17:0] exp_v, got;
    exp_v = model(n, cnt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      edge_vld_i = 1'b1;
      edge_time_i = ts[i];
    end
    @(negedge clk_i);
    edge_vld_i = 1'b0;
    frame_end_i = 1'b1;
    edge_cnt_i = 6'(cnt);
    @(negedge clk_i);
    frame_end_i = 1'b0;
    got = {done_o, valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o, payload_o};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s/%s: got %h expected %h", tag, tag_of(exp_v), got, exp_v);
    end
    @(negedge clk_i);
    n_chk++;
    if (done_o !== 1'b0 || {valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o} !== 5'b0) begin
      n_bad++;
      $display("FAIL R9: done/flags after pulse got %b%b%b%b%b%b expected 000000",
               done_o, valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(1234));
    repeat (3) @(negedge clk_i);
    n_chk++;
    if ({done_o, valid_o, no_resp_o, len_err_o, code_err_o, csum_err_o, payload_o} !== {6'b0, 12'hFFF}) begin
      n_bad++;
      $display("FAIL R1: got %b expected 0 flags, FFF", {done_o, valid_o, payload_o});
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (done_o !== 1'b0 || payload_o !== 12'hFFF) begin
      n_bad++;
      $display("FAIL R1: got done=%b payload=%h expected 0, FFF", done_o, payload_o);
    end

    // R7 directed: fixed payload, exact gaps
    n = build(code_of(12'h5A3, 1), 16'h0100, 0);
    run_frame(n, n, "R7");
    // R2 counter wrap inside frame
    n = build(code_of(12'h0C1, 1), 16'hFFC0, 1);
    run_frame(n, n, "R2");
    // R8 zero count with edges present
    run_frame(n, 0, "R8");
    // R8 zero count, no edges
    run_frame(0, 0, "R8");
    // R3 explicit final edge completes 21 bits, then garbage edges ignored
    n = build(code_of(12'h7E2, 1), 16'h1234, 1);
    ts[n] = ts[n-1] + 16'(OSR);
    for (int k = n + 1; k < n + 4; k++) ts[k] = 16'($urandom);
    run_frame(n + 4, n + 4, "R3");
    // R3 single edge: inferred run of 21
    ts[0] = 16'h4000;
    run_frame(1, 1, "R3");
    // R4 zero-length run
    n = build(code_of(12'h123, 1), 16'h2000, 0);
    ts[2] = ts[1] + 16'(OSR / 2 - 1);
    run_frame(n, n, "R4");
    // R4 overlong run
    ts[0] = 16'h3000; ts[1] = ts[0] + 16'(22 * OSR);
    run_frame(2, 2, "R4");
    // R6 bad checksum
    n = build(code_of(12'hABC, 0), 16'h5555, 1);
    run_frame(n, n, "R6");
    // R5 invalid group
    n = build(20'h00000 | {15'h0, 5'h00} | (20'h1 << 19), 16'h0042, 0);
    run_frame(n, n, "R5");
    // R10 edge in same cycle as frame end is dropped; next frame clean
    n = build(code_of(12'h9F0, 1), 16'h0700, 0);
    @(negedge clk_i);
    edge_vld_i = 1'b1; edge_time_i = 16'hBEEF; frame_end_i = 1'b1; edge_cnt_i = 6'd1;
    @(negedge clk_i);
    edge_vld_i = 1'b0; frame_end_i = 1'b0;
    run_frame(n, n, "R10");

    // random legal frames
    for (int it = 0; it < 150; it++) begin
      n = build(code_of(12'($urandom), 1), 16'($urandom), 1);
      run_frame(n, n, "R7");
    end
    // random corrupted frames
    for (int it = 0; it < 80; it++) begin
      case ($urandom_range(0, 3))
        0: n = build(code_of(12'($urandom), 0), 16'($urandom), 1);
        1: n = build(20'($urandom), 16'($urandom), 1);
        2: begin
          n = $urandom_range(1, 12);
          ts[0] = 16'($urandom);
          for (int k = 1; k < n; k++) ts[k] = ts[k-1] + 16'($urandom_range(0, 6 * OSR));
        end
        default: begin
          n = build(code_of(12'($urandom), 1), 16'($urandom), 1);
          ts[$urandom_range(1, n - 1)] ^= 16'($urandom_range(1, 255));
        end
      endcase
      run_frame(n, n, "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule